// File: doc/BRIEF.md
# Pin Change Interrupt Latch

This block watches a bank of GPIO ports and records, per pin, whether the level seen on that pin has changed since the host last read the port. Each port has one status byte. Reading a port returns the byte and clears it in the same access. A set status bit whose mask bit is 0 raises a single active-high interrupt line, so the host reads the ports to find out which pins moved and acknowledges them with the same read.

A pin can be handed over to a PWM generator. While a pin is routed to a PWM, the block watches the PWM level instead of the pad, so every PWM toggle counts as an event and pad activity on that pin is not seen. The pad inputs arrive already synchronized. The mask bits come from the configuration bank, and the read strobe and port index come from the register decoder.

The port count and port width are set in the package. Pin `p*PortW + b` is bit `b` of port `p` on every flat pin vector.

Top module: `gpio_change_irq`

## Requirements
- R1: While reset is asserted and after it ends, the read data, all status bits and `irq` are 0. The first level sampled after reset is a baseline and does not count as a change.
- R2: A level difference on a non-routed pin between two successive clock samples, in either direction, sets that pin's status bit at the next clock edge.
- R3: A status bit stays set until its own port is read. A read of any other port leaves it unchanged.
- R4: A read (`rdStrobe`=1 with `rdPort`=p at a clock edge) loads `rdData` at that edge with port p's status byte as it was before the edge, and clears that byte.
- R5: A change detected at the same edge as a clearing read of its port is not lost. That bit is 1 after the read.
- R6: When `pwmRouted` is 1 for a pin, the watched level is `pwmLevel` for that pin and `pinLevel` is ignored. Each PWM level toggle sets the status bit.
- R7: A mask bit of 1 keeps its pin's status bit from driving `irq`, but the status bit is still latched and can be read.
- R8: `irq` is 1 exactly when some status bit has a mask bit of 0. It follows mask changes without waiting for a clock edge.
- R9: `rdData` keeps its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinLevel | input | NumPorts*PortW | Synchronized pad levels |
| pwmRouted | input | NumPorts*PortW | 1 = pin is driven by a PWM |
| pwmLevel | input | NumPorts*PortW | Current PWM level for each pin |
| maskBits | input | NumPorts*PortW | 1 = pin may not raise `irq` |
| rdStrobe | input | 1 | Status read access this cycle |
| rdPort | input | IdxW | Port index of the read |
| rdData | output | PortW | Status byte captured by the last read |
| irq | output | 1 | Active-high interrupt |

## Verification
The bench targets the edge where a pin changes while its own port is being read. A design that clears after merging would drop that event, and one that returns the post-merge value would report it twice. It also checks that reading one port leaves the others intact, so that a decoder clearing every port is caught. Other targets are the first cycle after reset, where a design without a baseline would flag every high pin, and a PWM-routed pin whose pad toggles, which must stay silent. Masked pins must latch without raising the line, and the line must answer a mask change at once rather than one clock later.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned NumPorts = 8;
  localparam int unsigned PortW    = 8;
  localparam int unsigned IdxW     = (NumPorts > 1) ? $clog2(NumPorts) : 1;
  localparam int unsigned PinCount = NumPorts * PortW;

  typedef struct packed {
    logic                rdFire;
    logic [IdxW-1:0]     rdIdx;
    logic [NumPorts-1:0] clrPort;
    logic                primed;
  } ctrlStrobes_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            rdStrobe,
  input  logic [IdxW-1:0] rdPort,
  output ctrlStrobes_t    strb
);
  logic primedQ;

  // Baseline flag: the first sample after reset only seeds the history.
  always_ff @(posedge clk) begin
    if (!rstN) primedQ <= 1'b0;
    else       primedQ <= 1'b1;
  end

  logic [NumPorts-1:0] clrDec;
  for (genvar p = 0; p < NumPorts; p++) begin : g_dec
    assign clrDec[p] = rdStrobe && (rdPort == IdxW'(p));
  end

  always_comb begin
    strb.rdFire  = rdStrobe;
    strb.rdIdx   = rdPort;
    strb.clrPort = clrDec;
    strb.primed  = primedQ;
  end
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  input  logic [PinCount-1:0] pinLevel,
  input  logic [PinCount-1:0] pwmRouted,
  input  logic [PinCount-1:0] pwmLevel,
  input  logic [PinCount-1:0] maskBits,
  output logic [PortW-1:0]    rdData,
  output logic                irq,
  output logic [PinCount-1:0] statusFlat
);
  logic [NumPorts-1:0][PortW-1:0] statusQ;

  for (genvar p = 0; p < NumPorts; p++) begin : g_port
    logic [PortW-1:0] watched;
    logic [PortW-1:0] prevQ;
    logic [PortW-1:0] change;

    assign watched = (pwmRouted[p*PortW +: PortW] & pwmLevel[p*PortW +: PortW])
                   | (~pwmRouted[p*PortW +: PortW] & pinLevel[p*PortW +: PortW]);
    assign change  = strb.primed ? (watched ^ prevQ) : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevQ      <= '0;
        statusQ[p] <= '0;
      end else begin
        prevQ      <= watched;
        // Clear first, then merge, so a same-edge event survives the read.
        statusQ[p] <= (strb.clrPort[p] ? '0 : statusQ[p]) | change;
      end
    end

    assign statusFlat[p*PortW +: PortW] = statusQ[p];
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rdData <= '0;
    else if (strb.rdFire) rdData <= statusQ[strb.rdIdx];
  end

  assign irq = |(statusFlat & ~maskBits);
endmodule

// File: rtl/gpio_change_irq.sv
module gpio_change_irq
  import gpio_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [PinCount-1:0] pinLevel,
  input  logic [PinCount-1:0] pwmRouted,
  input  logic [PinCount-1:0] pwmLevel,
  input  logic [PinCount-1:0] maskBits,
  input  logic                rdStrobe,
  input  logic [IdxW-1:0]     rdPort,
  output logic [PortW-1:0]    rdData,
  output logic                irq
);
  ctrlStrobes_t        strb;
  logic [PinCount-1:0] statusFlat;

  gpio_irq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdStrobe (rdStrobe),
    .rdPort   (rdPort),
    .strb     (strb)
  );

  gpio_irq_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .pinLevel   (pinLevel),
    .pwmRouted  (pwmRouted),
    .pwmLevel   (pwmLevel),
    .maskBits   (maskBits),
    .rdData     (rdData),
    .irq        (irq),
    .statusFlat (statusFlat)
  );
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
  import gpio_irq_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                rdStrobe,
  input logic [IdxW-1:0]     rdPort,
  input logic [PortW-1:0]    rdData,
  input logic                irq,
  input logic [PinCount-1:0] maskBits,
  input logic [PinCount-1:0] statusFlat
);
  logic [PortW-1:0] selSlice;
  assign selSlice = statusFlat[rdPort*PortW +: PortW];

  // R3: without a read, no status bit may drop.
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> ((statusFlat & $past(statusFlat)) == $past(statusFlat)));

  // R4: read data equals the addressed byte before the edge.
  a_r4_read_value: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> (rdData == $past(selSlice)));

  // R9: read data holds between reads.
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> $stable(rdData));

  // R8: no status, no interrupt.
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    (statusFlat == '0) |-> !irq);

  // R7: everything masked, no interrupt.
  a_r7_all_masked: assert property (@(posedge clk) disable iff (!rstN)
    (&maskBits) |-> !irq);
endmodule

bind gpio_change_irq gpio_irq_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rdStrobe   (rdStrobe),
  .rdPort     (rdPort),
  .rdData     (rdData),
  .irq        (irq),
  .maskBits   (maskBits),
  .statusFlat (statusFlat)
);

// File: tb/sim_gpio_change_irq.sv
`timescale 1ns/1ps
module sim_gpio_change_irq;
  import gpio_irq_pkg::*;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [PinCount-1:0] pinLevel = '0;
  logic [PinCount-1:0] pwmRouted = '0;
  logic [PinCount-1:0] pwmLevel = '0;
  logic [PinCount-1:0] maskBits = '0;
  logic                rdStrobe = 1'b0;
  logic [IdxW-1:0]     rdPort = '0;
  logic [PortW-1:0]    rdData;
  logic                irq;

  int checks = 0;
  int errors = 0;

  // Reference state
  logic [PinCount-1:0] mStat = '0;
  logic [PinCount-1:0] mPrev = '0;
  logic                mPrimed = 1'b0;
  logic [PortW-1:0]    mRd = '0;

  always #2 clk = ~clk;

  gpio_change_irq u0 (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .pwmRouted(pwmRouted),
    .pwmLevel(pwmLevel), .maskBits(maskBits), .rdStrobe(rdStrobe),
    .rdPort(rdPort), .rdData(rdData), .irq(irq)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic expIrq();
    return |(mStat & ~maskBits);
  endfunction

  // One clock: update the model from the inputs applied now, then compare.
  task automatic step();
    logic [PinCount-1:0] watched;
    logic [PinCount-1:0] chg;
    watched = (pwmRouted & pwmLevel) | (~pwmRouted & pinLevel);
    chg     = mPrimed ? (watched ^ mPrev) : '0;
    if (rdStrobe) begin
      mRd = mStat[int'(rdPort)*PortW +: PortW];
      mStat[int'(rdPort)*PortW +: PortW] = '0;
    end
    mStat   = mStat | chg;
    mPrev   = watched;
    mPrimed = 1'b1;
    @(posedge clk); #1;
    chk(rdData == mRd, "R4 model rdData", rdData, mRd);
    chk(irq == expIrq(), "R8 model irq", irq, expIrq());
  endtask

  task automatic doRead(input int port, output logic [PortW-1:0] val);
    rdStrobe = 1'b1;
    rdPort   = IdxW'(port);
    step();
    rdStrobe = 1'b0;
    val = rdData;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [PortW-1:0] v;
    logic [PortW-1:0] held;
    pinLevel = {PinCount/4{4'hA}};
    repeat (3) @(posedge clk);
    #1;
    chk(rdData == '0, "R1 rdData in reset", rdData, 0);
    chk(irq == 1'b0, "R1 irq in reset", irq, 0);
    rstN = 1'b1;
    repeat (3) step();
    chk(irq == 1'b0, "R1 baseline no irq", irq, 0);
    doRead(0, v);
    chk(v == '0, "R1 baseline no status", v, 0);

    // R2: single pin rises
    pinLevel[2*PortW+0] = ~pinLevel[2*PortW+0];
    step();
    chk(irq == 1'b1, "R2 irq after change", irq, 1);
    doRead(2, v);
    chk(v == 8'h01, "R2 status of port 2", v, 8'h01);
    doRead(2, v);
    chk(v == 8'h00, "R4 cleared by read", v, 0);

    // R2 opposite direction, R3 read of other port keeps bits
    pinLevel[2*PortW+1] = ~pinLevel[2*PortW+1];
    pinLevel[5*PortW+1] = ~pinLevel[5*PortW+1];
    step();
    doRead(5, v);
    chk(v == 8'h02, "R3 port 5 value", v, 8'h02);
    chk(irq == 1'b1, "R3 port 2 still pending", irq, 1);
    doRead(2, v);
    chk(v == 8'h02, "R3 port 2 intact", v, 8'h02);

    // R5: change on the same edge as the clearing read
    pinLevel[4*PortW+6] = ~pinLevel[4*PortW+6];
    step();
    pinLevel[4*PortW+7] = ~pinLevel[4*PortW+7];
    doRead(4, v);
    chk(v == 8'h40, "R4 pre-clear value", v, 8'h40);
    chk(irq == 1'b1, "R5 event kept", irq, 1);
    doRead(4, v);
    chk(v == 8'h80, "R5 same-edge event", v, 8'h80);

    // R6: PWM routing on port 1 pin 0
    pwmLevel[1*PortW+0] = pinLevel[1*PortW+0];
    pwmRouted[1*PortW+0] = 1'b1;
    step();
    doRead(1, v);
    chk(v == 8'h00, "R6 route switch equal level", v, 0);
    pinLevel[1*PortW+0] = ~pinLevel[1*PortW+0];
    step();
    pinLevel[1*PortW+0] = ~pinLevel[1*PortW+0];
    step();
    chk(irq == 1'b0, "R6 pad ignored irq", irq, 0);
    doRead(1, v);
    chk(v == 8'h00, "R6 pad ignored status", v, 0);
    pwmLevel[1*PortW+0] = ~pwmLevel[1*PortW+0];
    step();
    doRead(1, v);
    chk(v == 8'h01, "R6 PWM toggle counted", v, 8'h01);

    // R7: masked pin latches silently
    maskBits[3*PortW +: PortW] = '1;
    pinLevel[3*PortW+2] = ~pinLevel[3*PortW+2];
    step();
    chk(irq == 1'b0, "R7 masked no irq", irq, 0);
    // R8: unmask raises irq without a clock edge
    maskBits[3*PortW +: PortW] = '0;
    #1;
    chk(irq == 1'b1, "R8 unmask immediate", irq, 1);
    maskBits[3*PortW +: PortW] = '1;
    #1;
    chk(irq == 1'b0, "R8 remask immediate", irq, 0);
    doRead(3, v);
    chk(v == 8'h04, "R7 masked bit latched", v, 8'h04);
    maskBits = '0;

    // R9: hold between reads
    held = rdData;
    pinLevel[6*PortW+3] = ~pinLevel[6*PortW+3];
    step();
    step();
    chk(rdData == held, "R9 rdData held", rdData, held);
    doRead(6, v);
    chk(v == 8'h08, "R9 next read updates", v, 8'h08);

    // Mixed random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(3) == 0) pinLevel[$urandom_range(PinCount-1)] ^= 1'b1;
      if ($urandom_range(5) == 0) pwmLevel[$urandom_range(PinCount-1)] ^= 1'b1;
      if ($urandom_range(40) == 0) pwmRouted[$urandom_range(PinCount-1)] ^= 1'b1;
      if ($urandom_range(30) == 0) maskBits[$urandom_range(PinCount-1)] ^= 1'b1;
      rdStrobe = ($urandom_range(2) == 0);
      rdPort   = IdxW'($urandom_range(NumPorts-1));
      step();
    end
    rdStrobe = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule